// File: doc/BRIEF.md
# Split-Transaction Memory Slave Port

This block is the slave end of a command/data link into a local dual-port memory. A master sends read and write commands with a 64-bit byte address, an 8-bit burst length and an 8-bit tag. Each beat of a burst is 128 bits wide. Write data travels on its own channel with a per-beat valid/accept handshake and a 16-bit byte-lane mask. Reads are split transactions. The command is taken at once and the link stays free. The data comes back later on a response channel that carries the request's tag and a status code.

Several reads can be outstanding at the same time. They queue in a pending-read FIFO whose depth is a parameter, and they are answered strictly in the order they were accepted. Writes are held off until every accepted read has been fully returned, so a read always sees memory as it was when it was accepted. The memory's second port goes straight to application logic. That port reads with one cycle of latency and writes with byte lanes.

Top module: `tagged_mem_slave`

## Requirements
- R1: `cmd_code` 3'b001 is a write and 3'b010 is a read. Every other code is idle and is never accepted. `cmd_accept` is high only in the cycle in which the command is taken.
- R2: A write with burst length N (0 counts as 1) consumes exactly N beats. `wr_accept` is high in each cycle where `wr_valid` is high and a beat of the open burst is still owed. After the last beat, `wr_accept` stays low even if `wr_valid` is high.
- R3: Byte-enable bit i controls data bits [8i+7:8i] of a beat. Lanes whose bit is clear keep their old memory contents.
- R4: A read with burst length N (0 counts as 1) returns N beats from consecutive words. Each beat carries the request's tag and status 2'b00. On an idle port, the first beat is valid two clock edges after the edge that accepted the command.
- R5: While `rsp_valid` is high and `rsp_accept` is low, `rsp_data`, `rsp_tag` and `rsp_valid` hold their values.
- R6: New read commands are accepted while earlier read data is still unreturned. Responses come back in acceptance order.
- R7: While responses are stalled and bursts are at least 2 beats long, RDQ_DEPTH+1 reads are accepted and further reads are refused.
- R8: A write command is not accepted while any read is queued, in progress or waiting on the response channel. No command is accepted while a write burst is open.
- R9: The application port writes by byte lane and returns read data one cycle after `app_en`. It shares storage with the bus side.
- R10: During reset, `cmd_accept`, `wr_accept` and `rsp_valid` are low.
- R11: Byte address bits [3:0] are ignored. The word index is address bits [4+log2(MEM_WORDS)-1:4], and bursts wrap modulo MEM_WORDS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_code | input | 3 | Command: idle, read or write |
| cmd_addr | input | ADDR_W | Byte address of first beat |
| cmd_len | input | LEN_W | Burst length in beats (0 = 1) |
| cmd_tag | input | TAG_W | Tag of a read command |
| cmd_accept | output | 1 | Command taken this cycle |
| wr_valid | input | 1 | Write beat present |
| wr_data | input | DATA_W | Write beat data |
| wr_be | input | DATA_W/8 | Write beat byte-lane enables |
| wr_accept | output | 1 | Write beat consumed this cycle |
| rsp_valid | output | 1 | Read beat present |
| rsp_data | output | DATA_W | Read beat data |
| rsp_tag | output | TAG_W | Tag of the read this beat belongs to |
| rsp_status | output | 2 | Beat status, 2'b00 = OK |
| rsp_accept | input | 1 | Master takes the read beat |
| app_en | input | 1 | Application port access |
| app_we | input | 1 | Application port write (else read) |
| app_addr | input | log2(MEM_WORDS) | Application word index |
| app_be | input | DATA_W/8 | Application byte-lane enables |
| app_wdata | input | DATA_W | Application write data |
| app_rdata | output | DATA_W | Application read data, one cycle after a read |

## Verification
The accept strobes are combinational, so they are due in the same cycle as the stimulus. The bench samples them 1 ns after driving at the falling edge, before the rising edge that completes the handshake. On an idle port, read data is due on the second rising edge after the accepting edge. Every later beat is due one edge after the previous beat was taken. Application reads are due one edge after `app_en`. The bench therefore samples at the falling edge, counts edges from acceptance for the latency check, and compares the held beat on every stalled cycle.

// File: rtl/tms_pkg.sv
package tms_pkg;
   typedef enum logic [2:0] {
      CMD_IDLE  = 3'b000,
      CMD_WRITE = 3'b001,
      CMD_READ  = 3'b010
   } cmd_e;

   localparam logic [1:0] RESP_OK = 2'b00;
endpackage

// File: rtl/tms_dpram.sv
module tms_dpram #(
   parameter int DATA_W = 128,
   parameter int WORDS  = 64
) (
   input  logic                     clk,
   input  logic                     a_en,
   input  logic                     a_we,
   input  logic [DATA_W/8-1:0]      a_be,
   input  logic [$clog2(WORDS)-1:0] a_addr,
   input  logic [DATA_W-1:0]        a_wdata,
   output logic [DATA_W-1:0]        a_q,
   input  logic                     b_en,
   input  logic                     b_we,
   input  logic [DATA_W/8-1:0]      b_be,
   input  logic [$clog2(WORDS)-1:0] b_addr,
   input  logic [DATA_W-1:0]        b_wdata,
   output logic [DATA_W-1:0]        b_q
);
   localparam int LANES = DATA_W / 8;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] lane_mem [WORDS];
      logic [7:0] qa, qb;
      always_ff @(posedge clk) begin
         if (a_en && a_we && a_be[g]) lane_mem[a_addr] <= a_wdata[8*g +: 8];
         if (b_en && b_we && b_be[g]) lane_mem[b_addr] <= b_wdata[8*g +: 8];
         if (a_en && !a_we) qa <= lane_mem[a_addr];
         if (b_en && !b_we) qb <= lane_mem[b_addr];
      end
      assign a_q[8*g +: 8] = qa;
      assign b_q[8*g +: 8] = qb;
   end
endmodule

// File: rtl/tms_rdq.sv
module tms_rdq #(
   parameter int W     = 24,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int PW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << PW) != DEPTH) begin : g_bad_depth
      $error("tms_rdq: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0] slots [DEPTH];
   logic [PW:0]  wptr, rptr;

   assign empty = (wptr == rptr);
   assign full  = (wptr[PW] != rptr[PW]) && (wptr[PW-1:0] == rptr[PW-1:0]);
   assign dout  = slots[rptr[PW-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
      end else begin
         if (push) begin
            slots[wptr[PW-1:0]] <= din;
            wptr <= wptr + 1'b1;
         end
         if (pop) rptr <= rptr + 1'b1;
      end
   end

   // R7: the queue is never pushed when full nor popped when empty
   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/tagged_mem_slave.sv
module tagged_mem_slave
   import tms_pkg::*;
#(
   parameter int ADDR_W    = 64,
   parameter int DATA_W    = 128,
   parameter int LEN_W     = 8,
   parameter int TAG_W     = 8,
   parameter int MEM_WORDS = 64,
   parameter int RDQ_DEPTH = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [2:0]                   cmd_code,
   input  logic [ADDR_W-1:0]            cmd_addr,
   input  logic [LEN_W-1:0]             cmd_len,
   input  logic [TAG_W-1:0]             cmd_tag,
   output logic                         cmd_accept,
   input  logic                         wr_valid,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic [DATA_W/8-1:0]          wr_be,
   output logic                         wr_accept,
   output logic                         rsp_valid,
   output logic [DATA_W-1:0]            rsp_data,
   output logic [TAG_W-1:0]             rsp_tag,
   output logic [1:0]                   rsp_status,
   input  logic                         rsp_accept,
   input  logic                         app_en,
   input  logic                         app_we,
   input  logic [$clog2(MEM_WORDS)-1:0] app_addr,
   input  logic [DATA_W/8-1:0]          app_be,
   input  logic [DATA_W-1:0]            app_wdata,
   output logic [DATA_W-1:0]            app_rdata
);
   localparam int BE_W  = DATA_W / 8;
   localparam int LSB   = $clog2(BE_W);
   localparam int MAW   = $clog2(MEM_WORDS);
   localparam int CNT_W = LEN_W + 1;
   localparam int ENT_W = MAW + CNT_W + TAG_W;

   if (DATA_W % 8 != 0 || (1 << LSB) != BE_W) begin : g_bad_data
      $error("tagged_mem_slave: DATA_W must be a power-of-two count of bytes");
   end
   if ((1 << MAW) != MEM_WORDS || LSB + MAW > ADDR_W) begin : g_bad_mem
      $error("tagged_mem_slave: MEM_WORDS must be a power of two within ADDR_W");
   end

   // ---------------- command decode ----------------
   logic             is_wr, is_rd, take_wr, take_rd, rd_pending;
   logic             q_empty, q_full, q_pop;
   logic [MAW-1:0]   cmd_word;
   logic [CNT_W-1:0] cmd_beats;
   logic             unused_addr_bits;

   assign is_wr     = (cmd_code == CMD_WRITE);
   assign is_rd     = (cmd_code == CMD_READ);
   assign cmd_word  = cmd_addr[LSB +: MAW];
   assign cmd_beats = (cmd_len == '0) ? CNT_W'(1) : CNT_W'(cmd_len);
   assign unused_addr_bits = ^{cmd_addr[ADDR_W-1:LSB+MAW], cmd_addr[LSB-1:0]};

   // ---------------- write engine ----------------
   logic             wr_busy;
   logic [MAW-1:0]   wr_word;
   logic [CNT_W-1:0] wr_left;

   // ---------------- read engine ----------------
   logic             rd_active, rd_issue, rsp_valid_q;
   logic [MAW-1:0]   rd_word;
   logic [CNT_W-1:0] rd_left;
   logic [TAG_W-1:0] rd_tag, rsp_tag_q;
   logic [ENT_W-1:0] q_din, q_dout;

   assign rd_pending = !q_empty || rd_active || rsp_valid_q;
   assign take_wr    = rst_n && is_wr && !wr_busy && !rd_pending;
   assign take_rd    = rst_n && is_rd && !wr_busy && !q_full;
   assign cmd_accept = take_wr || take_rd;
   assign wr_accept  = wr_busy && wr_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_busy <= 1'b0;
         wr_word <= '0;
         wr_left <= '0;
      end else if (take_wr) begin
         wr_busy <= 1'b1;
         wr_word <= cmd_word;
         wr_left <= cmd_beats;
      end else if (wr_accept) begin
         wr_word <= wr_word + 1'b1;
         wr_left <= wr_left - 1'b1;
         if (wr_left == CNT_W'(1)) wr_busy <= 1'b0;
      end
   end

   assign q_din = {cmd_word, cmd_beats, cmd_tag};
   assign q_pop = !rd_active && !q_empty;

   tms_rdq #(.W(ENT_W), .DEPTH(RDQ_DEPTH)) rdq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (take_rd),
      .din   (q_din),
      .pop   (q_pop),
      .dout  (q_dout),
      .empty (q_empty),
      .full  (q_full)
   );

   assign rd_issue = rd_active && (!rsp_valid_q || rsp_accept);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_active   <= 1'b0;
         rd_word     <= '0;
         rd_left     <= '0;
         rd_tag      <= '0;
         rsp_valid_q <= 1'b0;
         rsp_tag_q   <= '0;
      end else begin
         if (q_pop) begin
            rd_active <= 1'b1;
            {rd_word, rd_left, rd_tag} <= q_dout;
         end else if (rd_issue) begin
            rd_word <= rd_word + 1'b1;
            rd_left <= rd_left - 1'b1;
            if (rd_left == CNT_W'(1)) rd_active <= 1'b0;
         end
         if (rd_issue) begin
            rsp_valid_q <= 1'b1;
            rsp_tag_q   <= rd_tag;
         end else if (rsp_accept) begin
            rsp_valid_q <= 1'b0;
         end
      end
   end

   assign rsp_valid  = rsp_valid_q;
   assign rsp_tag    = rsp_tag_q;
   assign rsp_status = RESP_OK;

   // ---------------- storage ----------------
   logic             pa_en;
   logic [MAW-1:0]   pa_addr;

   assign pa_en   = wr_accept || rd_issue;
   assign pa_addr = wr_accept ? wr_word : rd_word;

   tms_dpram #(.DATA_W(DATA_W), .WORDS(MEM_WORDS)) ram_i (
      .clk     (clk),
      .a_en    (pa_en),
      .a_we    (wr_accept),
      .a_be    (wr_be),
      .a_addr  (pa_addr),
      .a_wdata (wr_data),
      .a_q     (rsp_data),
      .b_en    (app_en),
      .b_we    (app_we),
      .b_be    (app_be),
      .b_addr  (app_addr),
      .b_wdata (app_wdata),
      .b_q     (app_rdata)
   );

   // ---------------- assertions ----------------
   assert_idle_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_wr && !is_rd) |-> !cmd_accept);
   assert_rsp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_accept) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_tag)));
   assert_wr_vs_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_accept |-> (!rsp_valid && !rd_issue));
   assert_no_cmd_in_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_accept |-> !cmd_accept);
endmodule

// File: tb/tagged_mem_slave_tb.sv
module tagged_mem_slave_tb_top;
   import tms_pkg::*;

   localparam int WORDS = 64;
   localparam int DEPTH = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:0]   cmd_code = CMD_IDLE;
   logic [63:0]  cmd_addr = '0;
   logic [7:0]   cmd_len = '0;
   logic [7:0]   cmd_tag = '0;
   logic         cmd_accept;
   logic         wr_valid = 1'b0;
   logic [127:0] wr_data = '0;
   logic [15:0]  wr_be = '0;
   logic         wr_accept;
   logic         rsp_valid;
   logic [127:0] rsp_data;
   logic [7:0]   rsp_tag;
   logic [1:0]   rsp_status;
   logic         rsp_accept = 1'b0;
   logic         app_en = 1'b0;
   logic         app_we = 1'b0;
   logic [5:0]   app_addr = '0;
   logic [15:0]  app_be = '0;
   logic [127:0] app_wdata = '0;
   logic [127:0] app_rdata;

   always #5 clk = ~clk;

   tagged_mem_slave #(.MEM_WORDS(WORDS), .RDQ_DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_tag(cmd_tag),
      .cmd_accept(cmd_accept),
      .wr_valid(wr_valid), .wr_data(wr_data), .wr_be(wr_be), .wr_accept(wr_accept),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_tag(rsp_tag),
      .rsp_status(rsp_status), .rsp_accept(rsp_accept),
      .app_en(app_en), .app_we(app_we), .app_addr(app_addr), .app_be(app_be),
      .app_wdata(app_wdata), .app_rdata(app_rdata)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [127:0] model [WORDS];
   logic [5:0]   exp_word [16];
   logic [7:0]   exp_tag [16];

   typedef struct packed {
      logic [63:0] addr;
      logic [7:0]  len;
      logic [15:0] be;
      logic [7:0]  tag;
      logic [31:0] seed;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{64'h0000_0000_0000_0000, 8'd1, 16'hFFFF, 8'h11, 32'h1},
      '{64'h0000_0000_0000_0040, 8'd4, 16'hFFFF, 8'h22, 32'h2},
      '{64'h0000_0000_0000_0040, 8'd0, 16'h00FF, 8'h33, 32'h3},
      '{64'h1234_0000_0000_0105, 8'd3, 16'hA5A5, 8'h44, 32'h4},
      '{64'h0000_0000_0000_03F0, 8'd2, 16'hFFFF, 8'h55, 32'h5},
      '{64'h0000_0000_0000_0080, 8'd8, 16'h0F0F, 8'h66, 32'h6}
   };

   function automatic logic [127:0] pat(input logic [31:0] seed, input int beat);
      logic [31:0] m;
      m = seed * 32'h9E37_79B1 + 32'(beat) * 32'h0101_0101;
      return {m, ~m, m ^ 32'h5A5A_A5A5, seed + 32'(beat)};
   endfunction

   function automatic logic [5:0] word_of(input logic [63:0] a);
      return a[9:4];
   endfunction

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_wr(input logic [5:0] w, input logic [127:0] d, input logic [15:0] be);
      for (int i = 0; i < 16; i++)
         if (be[i]) model[w][8*i +: 8] = d[8*i +: 8];
   endtask

   task automatic issue_cmd(input logic [2:0] code, input logic [63:0] a, input logic [7:0] len,
                            input logic [7:0] tag, input int maxw, output bit got);
      @(negedge clk);
      cmd_code = code; cmd_addr = a; cmd_len = len; cmd_tag = tag;
      got = 1'b0;
      for (int k = 0; k < maxw; k++) begin
         #1;
         if (cmd_accept) got = 1'b1;
         @(posedge clk);
         @(negedge clk);
         if (got) break;
      end
      cmd_code = CMD_IDLE;
   endtask

   task automatic wr_burst(input logic [63:0] a, input logic [7:0] len, input logic [15:0] be,
                           input logic [31:0] seed, input bit gaps);
      bit got;
      int n;
      logic [5:0] w;
      n = (len == 0) ? 1 : int'(len);
      w = word_of(a);
      issue_cmd(CMD_WRITE, a, len, 8'h0, 8, got);
      chk(got, "R1 write command accepted", {127'b0, got}, 128'd1);
      for (int b = 0; b < n; b++) begin
         if (gaps && b == 1) begin
            wr_valid = 1'b0;
            @(posedge clk);
            @(negedge clk);
         end
         wr_valid = 1'b1; wr_data = pat(seed, b); wr_be = be;
         #1;
         chk(wr_accept, "R2 beat accepted", {127'b0, wr_accept}, 128'd1);
         if (wr_accept) model_wr(w + 6'(b), pat(seed, b), be);
         @(posedge clk);
         @(negedge clk);
      end
      wr_valid = 1'b0;
   endtask

   // Collects n beats described by exp_word/exp_tag; optional latency check (R4)
   task automatic collect(input int n, input bit lat, input bit stall);
      int got_n;
      int cyc;
      bit acc;
      got_n = 0;
      cyc = 0;
      while (got_n < n && cyc < 300) begin
         if (lat && cyc < 2) chk(!rsp_valid, "R4 latency early", {127'b0, rsp_valid}, 128'd0);
         if (lat && cyc == 2) chk(rsp_valid, "R4 latency due", {127'b0, rsp_valid}, 128'd1);
         acc = stall ? ((cyc % 3) != 1) : 1'b1;
         if (rsp_valid) begin
            chk(rsp_data == model[exp_word[got_n]], "R4/R5 read data", rsp_data,
                model[exp_word[got_n]]);
            chk(rsp_tag == exp_tag[got_n], "R4/R6 read tag", {120'b0, rsp_tag},
                {120'b0, exp_tag[got_n]});
            chk(rsp_status == RESP_OK, "R4 status", {126'b0, rsp_status}, 128'd0);
         end
         rsp_accept = acc;
         if (rsp_valid && acc) got_n++;
         @(posedge clk);
         @(negedge clk);
         cyc++;
      end
      rsp_accept = 1'b0;
      chk(got_n == n, "R4 beat count", 128'(got_n), 128'(n));
   endtask

   task automatic rd_burst(input logic [63:0] a, input logic [7:0] len, input logic [7:0] tag,
                           input bit lat, input bit stall);
      bit got;
      int n;
      n = (len == 0) ? 1 : int'(len);
      for (int b = 0; b < n; b++) begin
         exp_word[b] = word_of(a) + 6'(b);
         exp_tag[b] = tag;
      end
      issue_cmd(CMD_READ, a, len, tag, 8, got);
      chk(got, "R1 read command accepted", {127'b0, got}, 128'd1);
      collect(n, lat, stall);
   endtask

   task automatic app_wr(input logic [5:0] w, input logic [127:0] d, input logic [15:0] be);
      @(negedge clk);
      app_en = 1'b1; app_we = 1'b1; app_addr = w; app_wdata = d; app_be = be;
      @(posedge clk);
      @(negedge clk);
      app_en = 1'b0; app_we = 1'b0;
      model_wr(w, d, be);
   endtask

   task automatic app_rd(input logic [5:0] w, output logic [127:0] d);
      @(negedge clk);
      app_en = 1'b1; app_we = 1'b0; app_addr = w;
      @(posedge clk);
      @(negedge clk);
      app_en = 1'b0;
      d = app_rdata;
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=expired expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      vec_t cv;
      logic [127:0] d;
      bit got;
      int acc_cnt;

      // R10: outputs quiet while reset is held
      cmd_code = CMD_READ; wr_valid = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!cmd_accept, "R10 cmd_accept in reset", {127'b0, cmd_accept}, 128'd0);
      chk(!wr_accept, "R10 wr_accept in reset", {127'b0, wr_accept}, 128'd0);
      chk(!rsp_valid, "R10 rsp_valid in reset", {127'b0, rsp_valid}, 128'd0);
      cmd_code = CMD_IDLE; wr_valid = 1'b0;
      rst_n = 1'b1;

      // R1: codes other than 3'b001/3'b010 are never taken
      issue_cmd(3'b000, 64'h0, 8'd1, 8'h0, 3, got);
      chk(!got, "R1 code 000 idle", {127'b0, got}, 128'd0);
      issue_cmd(3'b111, 64'h0, 8'd1, 8'h0, 3, got);
      chk(!got, "R1 code 111 idle", {127'b0, got}, 128'd0);
      issue_cmd(3'b011, 64'h0, 8'd1, 8'h0, 3, got);
      chk(!got, "R1 code 011 idle", {127'b0, got}, 128'd0);

      // R9: fill memory through the application port, read one word back
      for (int w = 0; w < WORDS; w++) app_wr(6'(w), pat(32'hC0DE_0000 + 32'(w), 0), 16'hFFFF);
      app_rd(6'd5, d);
      chk(d == model[5], "R9 app read latency/data", d, model[5]);

      // Table-driven write then read-back round trips (R2, R3, R4, R11)
      for (int v = 0; v < 6; v++) begin
         cv = VECS[v];
         wr_burst(cv.addr, cv.len, cv.be, cv.seed, cv.seed[0]);
         rd_burst(cv.addr, cv.len, cv.tag, v == 0, v[0]);
      end

      // R9: bus write visible at application port; R3 app lane write seen by bus
      app_rd(6'd17, d);
      chk(d == model[17], "R9 app sees bus write", d, model[17]);
      app_wr(6'd20, 128'hDEAD_BEEF_0000_0000_0000_0000_0000_0000, 16'hF000);
      rd_burst(64'h140, 8'd1, 8'h77, 1'b0, 1'b0);

      // R6/R7/R5: stalled responses, capacity, ordering
      acc_cnt = 0;
      for (int i = 0; i < DEPTH + 2; i++) begin
         issue_cmd(CMD_READ, 64'(30 + 2 * i) << 4, 8'd2, 8'(i), 6, got);
         if (got) acc_cnt++;
      end
      chk(acc_cnt == DEPTH + 1, "R7 reads accepted before refusal", 128'(acc_cnt),
          128'(DEPTH + 1));
      chk(rsp_valid && rsp_tag == 8'd0, "R5 stalled beat held", {120'b0, rsp_tag}, 128'd0);
      @(negedge clk);
      chk(rsp_data == model[30], "R5 stalled data stable", rsp_data, model[30]);
      for (int b = 0; b < 2 * (DEPTH + 1); b++) begin
         exp_word[b] = 6'(30 + b);
         exp_tag[b] = 8'(b / 2);
      end
      collect(2 * (DEPTH + 1), 1'b0, 1'b1);

      // R8: write held off by a pending read, read held off by an open write burst
      rsp_accept = 1'b0;
      issue_cmd(CMD_READ, 64'h500, 8'd2, 8'h99, 6, got);
      issue_cmd(CMD_WRITE, 64'h500, 8'd1, 8'h0, 5, got);
      chk(!got, "R8 write refused while read pending", {127'b0, got}, 128'd0);
      exp_word[0] = 6'd16; exp_word[1] = 6'd17;
      exp_tag[0] = 8'h99; exp_tag[1] = 8'h99;
      collect(2, 1'b0, 1'b0);
      issue_cmd(CMD_WRITE, 64'h500, 8'd1, 8'h0, 5, got);
      chk(got, "R8 write accepted once reads drained", {127'b0, got}, 128'd1);
      issue_cmd(CMD_READ, 64'h0, 8'd1, 8'h1, 3, got);
      chk(!got, "R8 read refused during write burst", {127'b0, got}, 128'd0);
      wr_valid = 1'b1; wr_data = pat(32'h77, 0); wr_be = 16'hFFFF;
      #1;
      chk(wr_accept, "R2 single beat accepted", {127'b0, wr_accept}, 128'd1);
      model_wr(6'd16, pat(32'h77, 0), 16'hFFFF);
      @(posedge clk);
      @(negedge clk);
      wr_data = pat(32'h88, 0);
      #1;
      chk(!wr_accept, "R2 no beat after burst end", {127'b0, wr_accept}, 128'd0);
      @(posedge clk);
      @(negedge clk);
      wr_valid = 1'b0;
      rd_burst(64'h500, 8'd2, 8'hAB, 1'b0, 1'b0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule